// File: doc/BRIEF.md
# Four-State Transition Event Latch

The block watches a sequencer from the outside and walks a ring of four states, S0 to S1 to S2 to S3 and back to S0. It moves one step at most per clock. Each of the four steps has its own gate. A gate is made of five checks: the sequencer instruction pointer compared with a per-step reference value, the clock line, the transmit line, the receive line and the timeout line. Any check can be switched off. The checks that stay on must all hold in the same cycle for the step to be taken.

A check is judged either on the current level of its signal or on a change between the previous clock and the current one. For the pointer check, "high" means "equal to the reference". When the ring closes (the S3 to S0 step), the block captures the free-running time input and raises a one-cycle event flag. It also loads a delay counter. When that delay has run out, the block pulses one of several strobe outputs for a single clock. The output is the one selected at the moment of capture.

The named states are RING_S0, RING_S1, RING_S2 and RING_S3. The named steps are S0 to S1 (gate 0), S1 to S2 (gate 1), S2 to S3 (gate 2) and S3 to S0 (gate 3, the capture step). The delay engine has two conditions, idle and pending. A capture moves it from idle to pending. It returns to idle when it fires its strobe, or when the enable drops.

Top module: `evl_ring_latch`

## Requirements
- R1: While reset is asserted and after it is released, ring_state is 0, latch_time is 0, and event_flag and strobe_out are all 0.
- R2: ring_state changes only to the next state in the ring (3 wraps to 0), or to 0 when enable is low. It moves at most one step per clock.
- R3: In state k, gate k fires only when every check whose chk_off bit is 0 holds in that cycle. Checks whose chk_off bit is 1 have no effect. A gate with all five checks off advances on every enabled clock.
- R4: Check index c of gate k uses chk_off bit k*5+c and chk_cond bits [(k*5+c)*2+1 : (k*5+c)*2]. c is 0 pointer, 1 clock, 2 transmit, 3 receive, 4 timeout. Code 0 holds when the signal is high or the pointer matches. Code 1 holds when the signal is low or the pointer does not match.
- R5: Code 2 holds when the signal was low on the previous clock and is high now, or when the pointer did not match then and matches now. Code 3 holds for the opposite change. The history registers reset to 0 and update on every clock, whatever the enable.
- R6: The pointer check of gate k compares seq_ptr with ptr_ref bits [k*PTR_W+PTR_W-1 : k*PTR_W].
- R7: On the S3 to S0 step, latch_time takes the value of time_in in that cycle, and event_flag is high for exactly the following cycle. latch_time then holds until the next capture.
- R8: With delay value D, strobe_out has exactly one bit high for one cycle, D+1 cycles after the cycle in which event_flag is high. That bit is the index out_sel had at the capture. D=0 gives the strobe in the cycle right after the flag.
- R9: Driving enable low returns the ring to S0 on the next clock, holds it there, and cancels any pending strobe.
- R10: A new capture while a strobe is still pending reloads the delay and takes over the pending output. Only the latest capture produces a strobe.
- R11: At most one bit of strobe_out is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low holds the ring in S0 and cancels strobes |
| chk_off | input | 20 | Per-gate, per-check disable bits (1 = ignored) |
| chk_cond | input | 40 | Per-gate, per-check 2-bit condition code |
| ptr_ref | input | 4*PTR_W | Per-gate pointer reference values |
| dly | input | DLY_W | Delay from capture to strobe |
| out_sel | input | SEL_W | Strobe output index, taken at capture |
| seq_ptr | input | PTR_W | Sequencer instruction pointer |
| ck_in | input | 1 | Clock line being watched |
| txd_in | input | 1 | Transmit line being watched |
| rxd_in | input | 1 | Receive line being watched |
| tmo_in | input | 1 | Timeout signal |
| time_in | input | TIME_W | Free-running time count |
| ring_state | output | 2 | Current ring state |
| latch_time | output | TIME_W | Time captured at the last S3 to S0 step |
| event_flag | output | 1 | One-cycle pulse after a capture |
| strobe_out | output | N_OUT | Delayed one-cycle strobe on the selected bit |

## Verification
The hardest case to reach is a capture that lands while an earlier strobe is still waiting. It needs the ring to go all the way round faster than the delay runs out. The stimulus gets there by switching every check off on all four gates, so the ring laps every four clocks, and setting the delay longer than one lap. No strobe may appear while this runs. The first gate is then blocked to stop the ring, and exactly one strobe must follow. Edge codes are reached by holding enable low for one clock while the "before" value is applied, so the history register is loaded without the ring moving. The "after" value is then applied with enable high.

// File: rtl/evl_pkg.sv
package evl_pkg;
    localparam int N_STEP = 4;
    localparam int N_CHK  = 5;

    localparam int CHK_PTR = 0;
    localparam int CHK_CK  = 1;
    localparam int CHK_TXD = 2;
    localparam int CHK_RXD = 3;
    localparam int CHK_TMO = 4;

    typedef enum logic [1:0] {
        RING_S0 = 2'd0,
        RING_S1 = 2'd1,
        RING_S2 = 2'd2,
        RING_S3 = 2'd3
    } ring_st_t;

    typedef enum logic [1:0] {
        COND_LEVEL_HI = 2'd0,
        COND_LEVEL_LO = 2'd1,
        COND_RISE     = 2'd2,
        COND_FALL     = 2'd3
    } cond_t;
endpackage

// File: rtl/evl_check_eval.sv
module evl_check_eval
    import evl_pkg::*;
(
    input  logic       off,
    input  logic [1:0] cond,
    input  logic       now_v,
    input  logic       was_v,
    output logic       pass
);
    logic hit;

    always_comb begin
        unique case (cond_t'(cond))
            COND_LEVEL_HI: hit = now_v;
            COND_LEVEL_LO: hit = !now_v;
            COND_RISE:     hit = now_v && !was_v;
            COND_FALL:     hit = !now_v && was_v;
            default:       hit = 1'b0;
        endcase
    end

    // A disabled check never blocks its gate
    assign pass = off || hit;
endmodule

// File: rtl/evl_ring_fsm.sv
module evl_ring_fsm
    import evl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [N_STEP-1:0]   go,
    output ring_st_t            state,
    output logic                wrap
);
    ring_st_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RING_S0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;
        if (!en) begin
            state_d = RING_S0;
        end else begin
            unique case (state_q)
                RING_S0: if (go[0]) state_d = RING_S1;
                RING_S1: if (go[1]) state_d = RING_S2;
                RING_S2: if (go[2]) state_d = RING_S3;
                RING_S3: if (go[3]) begin
                    state_d = RING_S0;
                    wrap    = 1'b1;
                end
                default: state_d = RING_S0;
            endcase
        end
    end

    assign state = state_q;

    // R2: only a single ring step, a hold, or a return home
    a_r2_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q == $past(state_q)) || (state_q == RING_S0) ||
                 (state_q == ring_st_t'($past(state_q) + 2'd1)));

    // R9: enable low sends the ring home
    a_r9_disable_home: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == RING_S0);

    // R3: a closed gate holds the state
    a_r3_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !go[state_q]) |=> $stable(state_q));
endmodule

// File: rtl/evl_delay_strobe.sv
module evl_delay_strobe #(
    parameter int DLY_W = 16,
    parameter int N_OUT = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    input  logic [SEL_W-1:0] sel_in,
    output logic [N_OUT-1:0] strobe
);
    logic [DLY_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic             pend_q;
    logic [N_OUT-1:0] strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sel_q    <= '0;
            pend_q   <= 1'b0;
            strobe_q <= '0;
        end else begin
            strobe_q <= '0;
            if (!en) begin
                pend_q <= 1'b0;
            end else if (load) begin
                cnt_q  <= dly;
                sel_q  <= sel_in;
                pend_q <= 1'b1;
            end else if (pend_q) begin
                if (cnt_q == '0) begin
                    strobe_q[sel_q] <= 1'b1;
                    pend_q          <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign strobe = strobe_q;

    // R8: an expired pending delay yields exactly one strobe bit
    a_r8_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && pend_q && cnt_q == '0) |=> ($countones(strobe_q) == 1) && !pend_q);

    // R9: a disabled engine emits nothing
    a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (strobe_q == '0) && !pend_q);

    // R11: never more than one strobe output
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_q));
endmodule

// File: rtl/evl_ring_latch.sv
module evl_ring_latch
    import evl_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int TIME_W = 32,
    parameter int DLY_W  = 16,
    parameter int N_OUT  = 4,
    parameter int SEL_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [N_STEP*N_CHK-1:0]   chk_off,
    input  logic [N_STEP*N_CHK*2-1:0] chk_cond,
    input  logic [N_STEP*PTR_W-1:0]   ptr_ref,
    input  logic [DLY_W-1:0]          dly,
    input  logic [SEL_W-1:0]          out_sel,
    input  logic [PTR_W-1:0]          seq_ptr,
    input  logic                      ck_in,
    input  logic                      txd_in,
    input  logic                      rxd_in,
    input  logic                      tmo_in,
    input  logic [TIME_W-1:0]         time_in,
    output logic [1:0]                ring_state,
    output logic [TIME_W-1:0]         latch_time,
    output logic                      event_flag,
    output logic [N_OUT-1:0]          strobe_out
);
    localparam int N_LINE = N_CHK - 1;

    // Previous-clock history of the watched signals
    logic [PTR_W-1:0]  ptr_q;
    logic [N_LINE-1:0] line_q;
    logic [N_LINE-1:0] line_now;

    assign line_now = {tmo_in, rxd_in, txd_in, ck_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            line_q <= '0;
        end else begin
            ptr_q  <= seq_ptr;
            line_q <= line_now;
        end
    end

    logic [N_CHK-1:0]  pass_m [N_STEP];
    logic [N_STEP-1:0] go;

    for (genvar t = 0; t < N_STEP; t++) begin : g_step
        logic [PTR_W-1:0] ref_v;
        assign ref_v = ptr_ref[t*PTR_W +: PTR_W];

        for (genvar c = 0; c < N_CHK; c++) begin : g_chk
            logic now_b, was_b;
            if (c == CHK_PTR) begin : g_ptr
                assign now_b = (seq_ptr == ref_v);
                assign was_b = (ptr_q == ref_v);
            end else begin : g_line
                assign now_b = line_now[c-1];
                assign was_b = line_q[c-1];
            end
            evl_check_eval u_chk (
                .off   (chk_off[t*N_CHK + c]),
                .cond  (chk_cond[(t*N_CHK + c)*2 +: 2]),
                .now_v (now_b),
                .was_v (was_b),
                .pass  (pass_m[t][c])
            );
        end
        assign go[t] = &pass_m[t];
    end

    ring_st_t st;
    logic     wrap;

    evl_ring_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .go    (go),
        .state (st),
        .wrap  (wrap)
    );

    // Capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_time <= '0;
            event_flag <= 1'b0;
        end else begin
            event_flag <= wrap;
            if (wrap) latch_time <= time_in;
        end
    end

    evl_delay_strobe #(
        .DLY_W (DLY_W),
        .N_OUT (N_OUT),
        .SEL_W (SEL_W)
    ) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .load   (wrap),
        .dly    (dly),
        .sel_in (out_sel),
        .strobe (strobe_out)
    );

    assign ring_state = st;

    // R7: closing the ring captures time and flags the event
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == RING_S3 && go[3]) |=> event_flag && (latch_time == $past(time_in)));

    // R7: the flag only follows a closing step
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        event_flag |-> $past(st) == RING_S3 && st == RING_S0);
endmodule

// File: tb/tb_evl_ring_latch.sv
module tb_evl_ring_latch;
    localparam int PTR_W = 8, TIME_W = 32, DLY_W = 16, N_OUT = 4, SEL_W = 2;
    localparam int WD_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [19:0] chk_off = '1;
    logic [39:0] chk_cond = '0;
    logic [4*PTR_W-1:0] ptr_ref = '0;
    logic [DLY_W-1:0] dly = '0;
    logic [SEL_W-1:0] out_sel = '0;
    logic [PTR_W-1:0] seq_ptr = '0;
    logic ck_in = 0, txd_in = 0, rxd_in = 0, tmo_in = 0;
    logic [TIME_W-1:0] time_in = '0;
    logic [1:0] ring_state;
    logic [TIME_W-1:0] latch_time;
    logic event_flag;
    logic [N_OUT-1:0] strobe_out;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    evl_ring_latch dut (
        .clk(clk), .rst_n(rst_n), .en(en), .chk_off(chk_off), .chk_cond(chk_cond),
        .ptr_ref(ptr_ref), .dly(dly), .out_sel(out_sel), .seq_ptr(seq_ptr),
        .ck_in(ck_in), .txd_in(txd_in), .rxd_in(rxd_in), .tmo_in(tmo_in),
        .time_in(time_in), .ring_state(ring_state), .latch_time(latch_time),
        .event_flag(event_flag), .strobe_out(strobe_out)
    );

    // {check index, condition code, value before, value after, expect advance}
    localparam logic [7:0] VEC [18] = '{
        {3'd1, 2'd0, 1'b0, 1'b1, 1'b1},
        {3'd1, 2'd0, 1'b1, 1'b0, 1'b0},
        {3'd1, 2'd1, 1'b1, 1'b0, 1'b1},
        {3'd1, 2'd2, 1'b0, 1'b1, 1'b1},
        {3'd1, 2'd2, 1'b1, 1'b1, 1'b0},
        {3'd1, 2'd3, 1'b1, 1'b0, 1'b1},
        {3'd1, 2'd3, 1'b0, 1'b0, 1'b0},
        {3'd2, 2'd1, 1'b0, 1'b1, 1'b0},
        {3'd2, 2'd2, 1'b0, 1'b1, 1'b1},
        {3'd3, 2'd3, 1'b1, 1'b0, 1'b1},
        {3'd3, 2'd0, 1'b0, 1'b1, 1'b1},
        {3'd4, 2'd2, 1'b1, 1'b0, 1'b0},
        {3'd4, 2'd3, 1'b1, 1'b0, 1'b1},
        {3'd0, 2'd0, 1'b0, 1'b1, 1'b1},
        {3'd0, 2'd1, 1'b0, 1'b1, 1'b0},
        {3'd0, 2'd2, 1'b0, 1'b1, 1'b1},
        {3'd0, 2'd2, 1'b1, 1'b1, 1'b0},
        {3'd0, 2'd3, 1'b1, 1'b0, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_line(input int c, input logic v);
        case (c)
            0: seq_ptr = v ? 8'h5A : 8'h00;
            1: ck_in  = v;
            2: txd_in = v;
            3: rxd_in = v;
            default: tmo_in = v;
        endcase
    endtask

    task automatic home();
        en = 1'b0;
        tick();
        en = 1'b1;
    endtask

    initial begin
        #(WD_CYCLES * 8);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int hits;
        tick();
        // R1: reset values
        check("R1 state", 32'(ring_state), 0);
        check("R1 time", latch_time, 0);
        check("R1 flag/strobe", {27'd0, event_flag, strobe_out}, 0);
        rst_n = 1'b1;
        tick();
        check("R1 after release", {26'd0, ring_state, event_flag, strobe_out}, 0);

        // R4 R5 R6: table of single-check gate 0 patterns
        ptr_ref = {8'h00, 8'h00, 8'hFF, 8'h5A};
        for (int i = 0; i < 18; i++) begin
            int c;
            c = int'(VEC[i][7:5]);
            chk_off = '1;
            chk_cond = '0;
            chk_off[c] = 1'b0;
            chk_cond[c*2 +: 2] = VEC[i][4:3];
            chk_off[5] = 1'b0;          // gate 1 blocked: pointer must equal FF
            seq_ptr = 8'h00; ck_in = 0; txd_in = 0; rxd_in = 0; tmo_in = 0;
            en = 1'b0;
            put_line(c, VEC[i][2]);
            tick();
            en = 1'b1;
            put_line(c, VEC[i][1]);
            tick();
            check($sformatf("R4/R5/R6 vector %0d", i), 32'(ring_state), {31'd0, VEC[i][0]});
        end

        // R3: two enabled checks must both hold
        seq_ptr = 8'h00; ck_in = 0; txd_in = 0; rxd_in = 0; tmo_in = 0;
        chk_off = '1; chk_cond = '0;
        chk_off[1] = 1'b0; chk_off[2] = 1'b0; chk_off[5] = 1'b0;
        home();
        ck_in = 1; txd_in = 0;
        tick();
        check("R3 one of two holds", 32'(ring_state), 0);
        txd_in = 1;
        tick();
        check("R3 both hold", 32'(ring_state), 1);

        // R3 R2: all checks off advance every clock, wrapping
        chk_off = '1;
        home();
        tick();
        tick();
        tick();
        check("R3 R2 free run to S3", 32'(ring_state), 3);
        tick();
        check("R2 wrap to S0", 32'(ring_state), 0);

        // R7 R8: one lap, delay 3, output 2
        ck_in = 0; txd_in = 0;
        chk_off = '1; chk_off[1] = 1'b0;  // gate 0 waits for clock high
        dly = 16'd3; out_sel = 2'd2;
        time_in = 32'h1234_5678;
        home();
        ck_in = 1;
        tick();
        ck_in = 0;
        check("R2 step to S1", 32'(ring_state), 1);
        tick();
        tick();
        tick();
        check("R7 ring closed", 32'(ring_state), 0);
        check("R7 flag", 32'(event_flag), 1);
        check("R7 time captured", latch_time, 32'h1234_5678);
        time_in = 32'hDEAD_0000;
        out_sel = 2'd0;
        hits = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            if (strobe_out != 0) hits++;
        end
        check("R7 flag one cycle", 32'(event_flag), 0);
        check("R8 no early strobe", hits, 0);
        tick();
        check("R8 strobe on captured output", 32'(strobe_out), 32'h4);
        tick();
        check("R8 strobe one cycle", 32'(strobe_out), 0);
        check("R7 time holds", latch_time, 32'h1234_5678);
        check("R3 gate 0 stays closed", 32'(ring_state), 0);

        // R8: zero delay strobes right after the flag
        dly = 16'd0; out_sel = 2'd1;
        ck_in = 1;
        tick();
        ck_in = 0;
        tick(); tick(); tick();
        check("R8 D0 flag", 32'(event_flag), 1);
        check("R8 D0 no strobe with flag", 32'(strobe_out), 0);
        tick();
        check("R8 D0 strobe", 32'(strobe_out), 32'h2);

        // R9: disable cancels a pending strobe
        dly = 16'd5;
        ck_in = 1;
        tick();
        ck_in = 0;
        tick(); tick(); tick();
        check("R9 capture before disable", 32'(event_flag), 1);
        en = 1'b0;
        hits = 0;
        for (int k = 0; k < 8; k++) begin
            tick();
            if (strobe_out != 0) hits++;
        end
        check("R9 strobe cancelled", hits, 0);

        // R9: disable mid-ring returns to S0
        chk_off = '1;
        en = 1'b1;
        tick(); tick();
        check("R9 reached S2", 32'(ring_state), 2);
        en = 1'b0;
        tick();
        check("R9 back to S0", 32'(ring_state), 0);
        tick();
        check("R9 held in S0", 32'(ring_state), 0);

        // R10: laps faster than the delay keep restarting it
        dly = 16'd6; out_sel = 2'd3;
        en = 1'b1;
        hits = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (strobe_out != 0) hits++;
        end
        check("R10 no strobe while restarting", hits, 0);
        ck_in = 0;
        chk_off[1] = 1'b0;
        chk_cond[3:2] = 2'd0;
        hits = 0;
        for (int k = 0; k < 12; k++) begin
            tick();
            if (strobe_out == 4'h8) hits++;
            else if (strobe_out != 0) hits += 100;
        end
        check("R10 R11 single strobe after last capture", hits, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule